// File: doc/BRIEF.md
# Sixteen-Bit Multi-Mode Down-Counting Timer

This block is a 16-bit down-counter paired with a 16-bit holding register. Both are reached as byte lanes over a small register bus. The same two registers serve three purposes, chosen by a two-bit mode input.

In free-running reload mode, the counter steps once per instruction-cycle enable. When it would wrap, it refills from the holding register. In event mode, it steps on a chosen edge of an external pin and refills the same way. In capture mode, it steps every cycle, and a chosen pin edge copies the live count into the holding register.

A run input starts and stops counting. An edge-select input picks the active pin edge. A toggle-enable input lets each refill flip an output pin, which produces a square wave. An interrupt-enable input lets refills and captures raise a one-cycle pending pulse for the interrupt logic. The pin input is synchronised with two flops before any edge is detected.

Top module: `tmr16_timer`

## Requirements
- R1: After reset the counter, the holding register, `pin_out` and `pend_pulse` are all zero.
- R2: Register bus addresses are as follows: 0 is the counter low byte, 1 is the counter high byte, 2 is the holding low byte and 3 is the holding high byte. A write on address A with `wr_en` high takes effect at the next clock edge. `rd_data` shows the byte at `rd_addr` combinationally.
- R3: The counter does not change while `run` is 0, or while `tick` is 0 in any mode.
- R4: In mode 0 (reload), each clock with `run` and `tick` high decrements the counter. A step taken at 0x0000 loads the holding value instead of wrapping to 0xFFFF.
- R5: In modes 0 and 1, each refill flips `pin_out` when `tog_en` is 1. When `tog_en` is 0, `pin_out` is unchanged.
- R6: In mode 1 (event), the counter decrements only on the selected synchronised pin edge: rising when `edge_fall`=0, falling when `edge_fall`=1. The other edge has no effect. A step at 0x0000 refills from the holding register. The count changes on the third clock edge after the pin changes.
- R7: In mode 2 (capture), the counter decrements on every ticked clock and wraps from 0x0000 to 0xFFFF without a refill. On the selected pin edge, the count held before that cycle's decrement is copied into the holding register.
- R8: `pend_pulse` is high for exactly the one cycle after a refill (modes 0 and 1) or a capture (mode 2), and only if `irq_en` was 1 in that cycle.
- R9: A byte write to the counter in the same cycle as a step replaces that byte and cancels the step. The other counter byte keeps its value.
- R10: In modes 1 and 2, a pin edge that arrives while `tick` is 0 is held until the next ticked cycle. At most one edge is counted per ticked cycle.
- R11: In mode 3 the counter never steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Instruction-cycle enable |
| run | input | 1 | Counting enabled |
| mode | input | 2 | 0 reload, 1 event, 2 capture, 3 idle |
| edge_fall | input | 1 | Active pin edge: 0 rising, 1 falling |
| tog_en | input | 1 | Flip `pin_out` on each refill |
| irq_en | input | 1 | Allow refills and captures to raise `pend_pulse` |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 2 | Byte write address |
| wr_data | input | 8 | Byte write data |
| rd_addr | input | 2 | Byte read address |
| rd_data | output | 8 | Byte read data |
| pin_in | input | 1 | External timer pin, asynchronous |
| pin_out | output | 1 | Toggle output |
| pend_pulse | output | 1 | One-cycle pending event |

## Verification
The checker watches these rules on every cycle:
- the counter stays frozen when stopped or idle;
- a counter write beats a decrement;
- a refill loads exactly the holding value;
- `pin_out` moves only with `tog_en`;
- `pend_pulse` appears only with `irq_en`;
- the holding register changes only through a write or a capture-mode edge.

Other behaviour can only be shown by the bench's scenarios. This includes the exact latency through the pin synchroniser, rejection of the wrong edge, edges held while `tick` is low, the value captured, and the wrap in capture mode.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

   typedef enum logic [1:0] {
      TM_RELOAD  = 2'd0,
      TM_EVENT   = 2'd1,
      TM_CAPTURE = 2'd2,
      TM_IDLE    = 2'd3
   } tmr_mode_e;

endpackage

// File: rtl/tmr16_edge.sv
module tmr16_edge #(
   parameter int SYNC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_in,
   input  logic fall_sel,
   output logic edge_o
);
   generate
      if (SYNC < 2) begin : g_bad
         $error("tmr16_edge: SYNC must be at least 2");
      end
   endgenerate

   // sh[SYNC-1] is the synchronised pin, sh[SYNC] its previous value
   logic [SYNC:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[SYNC-1:0], pin_in};
   end

   assign edge_o = fall_sel ? (~sh[SYNC-1] &  sh[SYNC])
                            : ( sh[SYNC-1] & ~sh[SYNC]);
endmodule

// File: rtl/tmr16_bytereg.sv
module tmr16_bytereg #(
   parameter int W    = 16,
   parameter int BYTE = 8,
   localparam int NB  = W / BYTE
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NB-1:0]   byte_we,
   input  logic [BYTE-1:0] wdata,
   input  logic            load,
   input  logic [W-1:0]    load_val,
   output logic [W-1:0]    q
);
   // a bus write on a lane wins over a load on that lane
   for (genvar i = 0; i < NB; i++) begin : g_lane
      logic [BYTE-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          r <= '0;
         else if (byte_we[i]) r <= wdata;
         else if (load)       r <= load_val[i*BYTE +: BYTE];
      end
      assign q[i*BYTE +: BYTE] = r;
   end
endmodule

// File: rtl/tmr16_ctrl.sv
module tmr16_ctrl
   import tmr16_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         run,
   input  logic [1:0]   mode,
   input  logic         tog_en,
   input  logic         irq_en,
   input  logic         edge_ev,
   input  logic         cnt_wr,
   input  logic [W-1:0] cnt_q,
   input  logic [W-1:0] hold_q,
   output logic         cnt_load,
   output logic [W-1:0] cnt_next,
   output logic         cap_load,
   output logic         pin_out,
   output logic         pend_pulse
);
   tmr_mode_e md;
   logic      ev_held, ev, pin_mode, periodic, count_en, refill;

   assign md       = tmr_mode_e'(mode);
   assign pin_mode = (md == TM_EVENT) || (md == TM_CAPTURE);
   assign periodic = (md == TM_RELOAD) || (md == TM_CAPTURE);
   assign ev       = edge_ev | ev_held;

   // keep one pending edge until the next ticked cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          ev_held <= 1'b0;
      else if (!run || tick)               ev_held <= 1'b0;
      else if (edge_ev && pin_mode)        ev_held <= 1'b1;
   end

   assign count_en = run && tick && (periodic || (md == TM_EVENT && ev));
   assign cnt_load = count_en && !cnt_wr;
   assign refill   = cnt_load && (cnt_q == '0) &&
                     (md == TM_RELOAD || md == TM_EVENT);
   assign cnt_next = refill ? hold_q : (cnt_q - W'(1));
   assign cap_load = run && tick && (md == TM_CAPTURE) && ev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_out    <= 1'b0;
         pend_pulse <= 1'b0;
      end else begin
         if (refill && tog_en) pin_out <= ~pin_out;
         pend_pulse <= irq_en && (refill || cap_load);
      end
   end
endmodule

// File: rtl/tmr16_timer.sv
module tmr16_timer #(
   parameter int W    = 16,
   parameter int BYTE = 8,
   parameter int SYNC = 2,
   localparam int NB     = W / BYTE,
   localparam int ADDR_W = $clog2(2 * NB)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              run,
   input  logic [1:0]        mode,
   input  logic              edge_fall,
   input  logic              tog_en,
   input  logic              irq_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BYTE-1:0]   wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [BYTE-1:0]   rd_data,
   input  logic              pin_in,
   output logic              pin_out,
   output logic              pend_pulse
);
   generate
      if ((W % BYTE) != 0) begin : g_bad_w
         $error("tmr16_timer: W must be a multiple of BYTE");
      end
      if ((1 << ADDR_W) != 2 * NB) begin : g_bad_nb
         $error("tmr16_timer: W/BYTE must be a power of two");
      end
   endgenerate

   logic [NB-1:0] cnt_we, hold_we;
   logic [W-1:0]  cnt_q, hold_q, cnt_next;
   logic          cnt_load, cap_load, edge_ev;

   for (genvar i = 0; i < NB; i++) begin : g_dec
      assign cnt_we[i]  = wr_en && (wr_addr == ADDR_W'(i));
      assign hold_we[i] = wr_en && (wr_addr == ADDR_W'(NB + i));
   end

   tmr16_edge #(.SYNC(SYNC)) u_edge (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
      .fall_sel(edge_fall), .edge_o(edge_ev)
   );

   tmr16_ctrl #(.W(W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .mode(mode),
      .tog_en(tog_en), .irq_en(irq_en), .edge_ev(edge_ev),
      .cnt_wr(|cnt_we), .cnt_q(cnt_q), .hold_q(hold_q),
      .cnt_load(cnt_load), .cnt_next(cnt_next), .cap_load(cap_load),
      .pin_out(pin_out), .pend_pulse(pend_pulse)
   );

   tmr16_bytereg #(.W(W), .BYTE(BYTE)) u_cnt (
      .clk(clk), .rst_n(rst_n), .byte_we(cnt_we), .wdata(wr_data),
      .load(cnt_load), .load_val(cnt_next), .q(cnt_q)
   );

   tmr16_bytereg #(.W(W), .BYTE(BYTE)) u_hold (
      .clk(clk), .rst_n(rst_n), .byte_we(hold_we), .wdata(wr_data),
      .load(cap_load), .load_val(cnt_q), .q(hold_q)
   );

   logic [2*NB-1:0][BYTE-1:0] rd_bank;
   assign rd_bank = {hold_q, cnt_q};
   assign rd_data = rd_bank[rd_addr];
endmodule

// File: rtl/tmr16_chk.sv
module tmr16_chk #(
   parameter int W    = 16,
   parameter int BYTE = 8,
   localparam int NB     = W / BYTE,
   localparam int ADDR_W = $clog2(2 * NB)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              run,
   input logic [1:0]        mode,
   input logic              tog_en,
   input logic              irq_en,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [BYTE-1:0]   wr_data,
   input logic [W-1:0]      cnt_q,
   input logic [W-1:0]      hold_q,
   input logic              pin_out,
   input logic              pend_pulse
);
   logic cwr, hwr;
   assign cwr = wr_en && (wr_addr < ADDR_W'(NB));
   assign hwr = wr_en && (wr_addr >= ADDR_W'(NB));

   // R3
   frozen_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((!run || !tick) && !cwr) |=> $stable(cnt_q));

   // R9
   write_beats_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == '0) |=> (cnt_q[BYTE-1:0] == $past(wr_data)));

   // R4
   reload_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && mode == 2'd0 && cnt_q == '0 && !cwr) |=> (cnt_q == $past(hold_q)));

   // R5
   toggle_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pin_out) |-> $past(tog_en));

   // R8
   pend_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_pulse |-> $past(irq_en));

   // R7
   hold_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(hold_q) && !$past(hwr)) |-> ($past(mode) == 2'd2));

   // R11
   idle_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd3 && !cwr) |=> $stable(cnt_q));
endmodule

bind tmr16_timer tmr16_chk #(.W(W), .BYTE(BYTE)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .mode(mode),
   .tog_en(tog_en), .irq_en(irq_en), .wr_en(wr_en), .wr_addr(wr_addr),
   .wr_data(wr_data), .cnt_q(cnt_q), .hold_q(hold_q),
   .pin_out(pin_out), .pend_pulse(pend_pulse)
);

// File: tb/sim_tmr16_timer.sv
`timescale 1ns/100ps
module sim_tmr16_timer;
   logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b1, run = 1'b0;
   logic [1:0] mode = 2'd0, wr_addr = 2'd0, rd_addr = 2'd0;
   logic       edge_fall = 1'b0, tog_en = 1'b0, irq_en = 1'b0, wr_en = 1'b0;
   logic [7:0] wr_data = 8'd0, rd_data;
   logic       pin_in = 1'b0, pin_out, pend_pulse;
   int         nvec = 0, nerr = 0;
   bit         done = 1'b0;

   always #2.5 clk = ~clk;

   tmr16_timer u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .mode(mode),
      .edge_fall(edge_fall), .tog_en(tog_en), .irq_en(irq_en),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .pin_in(pin_in),
      .pin_out(pin_out), .pend_pulse(pend_pulse)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      step(1);
      wr_en = 1'b0;
   endtask

   task automatic wr16(input logic sel_hold, input logic [15:0] v);
      wr({sel_hold, 1'b0}, v[7:0]);
      wr({sel_hold, 1'b1}, v[15:8]);
   endtask

   task automatic rd16(input logic sel_hold, output logic [15:0] v);
      rd_addr = {sel_hold, 1'b0}; #0.2; v[7:0]  = rd_data;
      rd_addr = {sel_hold, 1'b1}; #0.2; v[15:8] = rd_data;
   endtask

   task automatic t_reset;
      logic [15:0] v;
      rd16(1'b0, v); chk("R1 counter", v, 16'h0);
      rd16(1'b1, v); chk("R1 hold", v, 16'h0);
      chk("R1 pin_out", pin_out, 1'b0);
      chk("R1 pend", pend_pulse, 1'b0);
   endtask

   task automatic t_regmap;
      wr(2'd0, 8'h34); wr(2'd1, 8'h12); wr(2'd2, 8'hCD); wr(2'd3, 8'hAB);
      rd_addr = 2'd0; #0.2; chk("R2 byte0", rd_data, 8'h34);
      rd_addr = 2'd1; #0.2; chk("R2 byte1", rd_data, 8'h12);
      rd_addr = 2'd2; #0.2; chk("R2 byte2", rd_data, 8'hCD);
      rd_addr = 2'd3; #0.2; chk("R2 byte3", rd_data, 8'hAB);
   endtask

   task automatic t_freeze;
      logic [15:0] v;
      mode = 2'd0; wr16(1'b0, 16'h0020);
      step(5); rd16(1'b0, v); chk("R3 run low", v, 16'h0020);
      tick = 1'b0; run = 1'b1;
      step(5); rd16(1'b0, v); chk("R3 tick low", v, 16'h0020);
      run = 1'b0; tick = 1'b1;
   endtask

   task automatic t_reload;
      logic [15:0] v;
      mode = 2'd0; tog_en = 1'b1; irq_en = 1'b1;
      wr16(1'b0, 16'd3); wr16(1'b1, 16'd5);
      run = 1'b1;
      step(4);
      rd16(1'b0, v); chk("R4 refill", v, 16'd5);
      chk("R5 toggle", pin_out, 1'b1);
      chk("R8 pend after refill", pend_pulse, 1'b1);
      step(1);
      rd16(1'b0, v); chk("R4 continue", v, 16'd4);
      chk("R8 pend one cycle", pend_pulse, 1'b0);
      run = 1'b0;
   endtask

   task automatic t_reload_quiet;
      logic [15:0] v;
      mode = 2'd0; tog_en = 1'b0; irq_en = 1'b0;
      wr16(1'b0, 16'd1); wr16(1'b1, 16'd9);
      run = 1'b1;
      step(2);
      rd16(1'b0, v); chk("R4 refill 9", v, 16'd9);
      chk("R5 no toggle", pin_out, 1'b1);
      chk("R8 masked", pend_pulse, 1'b0);
      run = 1'b0;
   endtask

   task automatic t_event;
      logic [15:0] v;
      mode = 2'd1; edge_fall = 1'b0; irq_en = 1'b1; tog_en = 1'b0;
      wr16(1'b0, 16'd1); wr16(1'b1, 16'd7);
      run = 1'b1;
      pin_in = 1'b1; step(3);
      rd16(1'b0, v); chk("R6 rise counts", v, 16'd0);
      pin_in = 1'b0; step(3);
      rd16(1'b0, v); chk("R6 fall ignored", v, 16'd0);
      pin_in = 1'b1; step(3);
      rd16(1'b0, v); chk("R6 refill", v, 16'd7);
      chk("R8 event pend", pend_pulse, 1'b1);
      edge_fall = 1'b1;
      pin_in = 1'b0; step(3);
      rd16(1'b0, v); chk("R6 fall selected", v, 16'd6);
      run = 1'b0; edge_fall = 1'b0;
   endtask

   task automatic t_one_per_tick;
      logic [15:0] v;
      mode = 2'd1; tick = 1'b0;
      wr16(1'b0, 16'd10);
      run = 1'b1;
      pin_in = 1'b1; step(3); pin_in = 1'b0; step(3);
      pin_in = 1'b1; step(3); pin_in = 1'b0; step(3);
      rd16(1'b0, v); chk("R10 held while tick low", v, 16'd10);
      tick = 1'b1; step(1); tick = 1'b0;
      rd16(1'b0, v); chk("R10 one edge counted", v, 16'd9);
      tick = 1'b1; step(3);
      rd16(1'b0, v); chk("R10 held edge consumed", v, 16'd9);
      run = 1'b0;
   endtask

   task automatic t_capture;
      logic [15:0] v;
      mode = 2'd2; irq_en = 1'b1; edge_fall = 1'b0;
      wr16(1'b0, 16'd100); wr16(1'b1, 16'd0);
      run = 1'b1; pin_in = 1'b1;
      step(3);
      rd16(1'b1, v); chk("R7 captured", v, 16'd98);
      rd16(1'b0, v); chk("R7 count", v, 16'd97);
      chk("R8 capture pend", pend_pulse, 1'b1);
      run = 1'b0;
      wr16(1'b0, 16'd0);
      run = 1'b1; step(1); run = 1'b0;
      rd16(1'b0, v); chk("R7 wraps", v, 16'hFFFF);
      rd16(1'b1, v); chk("R7 hold kept", v, 16'd98);
      chk("R8 no pend on wrap", pend_pulse, 1'b0);
   endtask

   task automatic t_write_priority;
      logic [15:0] v;
      mode = 2'd0; tick = 1'b1; irq_en = 1'b0;
      wr16(1'b0, 16'h0100);
      run = 1'b1; step(1);
      rd16(1'b0, v); chk("R4 borrow", v, 16'h00FF);
      wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h33;
      step(1);
      wr_en = 1'b0; run = 1'b0;
      rd16(1'b0, v); chk("R9 write wins", v, 16'h0033);
   endtask

   task automatic t_idle;
      logic [15:0] v;
      mode = 2'd3; run = 1'b1; step(4); run = 1'b0;
      rd16(1'b0, v); chk("R11 idle", v, 16'h0033);
   endtask

   task automatic finish_sim;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   endtask

   initial begin
      #1000000;
      if (!done) begin
         nvec++; nerr++;
         $display("FAIL watchdog actual=running expected=finished");
         finish_sim();
      end
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      t_reset();
      t_regmap();
      t_freeze();
      t_reload();
      t_reload_quiet();
      t_event();
      t_one_per_tick();
      t_capture();
      t_write_priority();
      t_idle();
      done = 1'b1;
      finish_sim();
   end
endmodule